// File: doc/BRIEF.md
# Vocoder Channel Frame Packer

This block sits between a compressed-speech codec core and a host that owns a bit-serial channel link. The host drives the shift clock and a frame strobe. The block moves one fixed 272-bit frame per strobe. The frame is 17 words of 16 bits: five leading words for the header, ID and status/control fields, then twelve payload words.

On the transmit side the codec writes all 17 words into a word buffer over a parallel port. The block then shifts the frame out MSB first, in word order. Any payload bit past the count set by the rate code is forced to zero, but all 272 bits are still sent.

On the receive side the block deserializes the incoming frame and compares word 0 against a fixed header value. When the header matches, words 1 to 16 are delivered with their index. When it does not match, an error pulse is raised and the rest of that frame is dropped.

The link inputs are oversampled by the system clock, so any host clock works if each of its phases lasts at least three system clocks. A 20 ms frame period needs only 13.6 kbit/s.

Top module: `chan_frame_codec`

## Requirements
- R1: A frame is 272 serial bits, 17 words of 16 bits sent in index order 0..16, each word MSB first. Bit k of the frame is word k/16, bit 15-(k mod 16). On the transmit side, bit 0 is on sdo_o while idle, and bit k+1 replaces bit k after the k-th shift-clock rising edge.
- R2: A frame starts on a shift-clock rising edge at which fs_i is high while the block is idle. Rising edges of sclk_i while idle with fs_i low are ignored.
- R3: The payload bit count is 48 + rate_code_i, which covers 2400..9600 b/s in 50 b/s steps. Codes above 144 give 192. Frame bits 80+count through 271 are sent as zero; header and control words 0..4 are never masked.
- R4: rate_code_i is sampled on the first edge of a frame. Changes during the frame have no effect on that frame.
- R5: frame_done_o pulses for one cycle after the 272nd rising edge. The block then returns to idle and needs a new fs_i to start again.
- R6: Receive bits are captured on the same edges as transmit bits. When word 0 equals the HDR_WORD parameter (default 16'hA5C3), words 1..16 are each presented once on rx_word_o/rx_idx_o with a one-cycle rx_vld_o. rx_ok_o pulses once at frame end.
- R7: When word 0 differs from HDR_WORD, hdr_err_o pulses once. No word of that frame is delivered and rx_ok_o stays low.
- R8: tx_we_i with tx_addr_i in 0..16 stores tx_wdata_i into that word of the transmit buffer. Addresses 17..31 change nothing.
- R9: After reset the transmit buffer is zero, sdo_o is 0, and rx_vld_o, hdr_err_o, rx_ok_o and frame_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_we_i | input | 1 | Transmit buffer write strobe |
| tx_addr_i | input | 5 | Transmit buffer word index |
| tx_wdata_i | input | 16 | Transmit buffer write data |
| rate_code_i | input | 8 | Rate code, payload bits = 48 + code |
| sclk_i | input | 1 | Host-driven shift clock |
| fs_i | input | 1 | Frame strobe, qualifies bit 0 |
| sdi_i | input | 1 | Serial receive data |
| sdo_o | output | 1 | Serial transmit data |
| rx_word_o | output | 16 | Received word |
| rx_idx_o | output | 5 | Index of received word |
| rx_vld_o | output | 1 | Received word valid pulse |
| hdr_err_o | output | 1 | Header mismatch pulse |
| rx_ok_o | output | 1 | Frame received with valid header |
| frame_done_o | output | 1 | Frame complete pulse |

## Verification
Several properties are checked on every cycle:
- the latched payload count stays within 48..192 and does not change mid-frame;
- padded positions drive zero;
- the done pulse coincides with the idle state;
- no word is delivered without an accepted header, and word 0 is never delivered.

The bit order, the exact position where zero fill begins, and what arrives on the receive side need scenarios:
- full, minimum, clamped and mid-word rate boundaries;
- a rate change inside a frame;
- a bad header;
- stray shift clocks before a frame.

Those scenarios are checked against a scoreboard of expected words.

// File: rtl/chan_frame_pkg.sv
package chan_frame_pkg;
  localparam int WORD_W     = 16;
  localparam int N_WORDS    = 17;
  localparam int HDR_WORDS  = 5;
  localparam int FRAME_BITS = WORD_W * N_WORDS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int IDX_W      = $clog2(N_WORDS);
  localparam int PAY_OFS    = WORD_W * HDR_WORDS;
  localparam int RATE_W     = 8;
  localparam int MIN_BITS   = 48;
  localparam int MAX_BITS   = 192;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [RATE_W-1:0] rate_t;

  function automatic rate_t rate_to_bits(rate_t code);
    if (code > rate_t'(MAX_BITS - MIN_BITS)) return rate_t'(MAX_BITS);
    return code + rate_t'(MIN_BITS);
  endfunction
endpackage

// File: rtl/cfc_sync.sv
module cfc_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/cfc_tx.sv
module cfc_tx
  import chan_frame_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  idx_t  addr_i,
  input  word_t wdata_i,
  input  cnt_t  cnt_i,
  input  rate_t rate_bits_i,
  output logic  sdo_o
);
  word_t mem_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[w] <= '0;
      else if (we_i && addr_i == idx_t'(w))   mem_q[w] <= wdata_i;
    end
  end

  idx_t  widx;
  logic [3:0] bidx;
  cnt_t  pay_pos;
  logic  pad, bit_raw;

  always_comb begin
    widx    = cnt_i[CNT_W-1:4];
    bidx    = cnt_i[3:0];
    pay_pos = cnt_i - cnt_t'(PAY_OFS);
    pad     = (cnt_i >= cnt_t'(PAY_OFS)) && (pay_pos >= cnt_t'(rate_bits_i));
    bit_raw = mem_q[widx][4'd15 - bidx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_o <= 1'b0;
    else         sdo_o <= bit_raw & ~pad;
  end
endmodule

// File: rtl/cfc_rx.sv
module cfc_rx
  import chan_frame_pkg::*;
#(
  parameter logic [15:0] HDR_WORD = 16'hA5C3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  go_i,
  input  cnt_t  cnt_i,
  input  logic  sdi_i,
  output word_t word_o,
  output idx_t  idx_o,
  output logic  vld_o,
  output logic  hdr_err_o,
  output logic  ok_o
);
  word_t sr_q, word_nxt;
  logic  hdr_ok_q, word_end, frame_end;

  always_comb begin
    word_nxt  = {sr_q[WORD_W-2:0], sdi_i};
    word_end  = go_i && (cnt_i[3:0] == 4'hF);
    frame_end = go_i && (cnt_i == cnt_t'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0; hdr_ok_q <= 1'b0; word_o <= '0; idx_o <= '0;
      vld_o <= 1'b0; hdr_err_o <= 1'b0; ok_o <= 1'b0;
    end else begin
      vld_o     <= 1'b0;
      hdr_err_o <= 1'b0;
      ok_o      <= frame_end && hdr_ok_q;
      if (go_i) sr_q <= word_nxt;
      if (word_end) begin
        if (cnt_i[CNT_W-1:4] == '0) begin
          hdr_ok_q  <= (word_nxt == HDR_WORD);
          hdr_err_o <= (word_nxt != HDR_WORD);
        end else if (hdr_ok_q) begin
          vld_o  <= 1'b1;
          word_o <= word_nxt;
          idx_o  <= cnt_i[CNT_W-1:4];
        end
      end
    end
  end

  AST_WORD_NEEDS_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> hdr_ok_q); // R6
  AST_NO_HDR_DELIVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> idx_o != '0); // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |-> !vld_o && !hdr_ok_q); // R7
  AST_OK_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> cnt_i == '0); // R6
endmodule

// File: rtl/chan_frame_codec.sv
module chan_frame_codec
  import chan_frame_pkg::*;
#(
  parameter logic [15:0] HDR_WORD = 16'hA5C3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_we_i,
  input  logic [4:0]  tx_addr_i,
  input  logic [15:0] tx_wdata_i,
  input  logic [7:0]  rate_code_i,
  input  logic        sclk_i,
  input  logic        fs_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic [15:0] rx_word_o,
  output logic [4:0]  rx_idx_o,
  output logic        rx_vld_o,
  output logic        hdr_err_o,
  output logic        rx_ok_o,
  output logic        frame_done_o
);
  logic [2:0] sync_q;
  logic sclk_s, fs_s, sdi_s, sclk_d, rise, go, start, last;
  cnt_t  cnt_q;
  rate_t rate_q;

  cfc_sync #(.N(3), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i({sclk_i, fs_i, sdi_i}), .q_o(sync_q)
  );
  assign {sclk_s, fs_s, sdi_s} = sync_q;

  always_comb begin
    rise  = sclk_s & ~sclk_d;
    start = rise && (cnt_q == '0) && fs_s;
    go    = rise && ((cnt_q != '0) || fs_s);
    last  = (cnt_q == cnt_t'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0; cnt_q <= '0; frame_done_o <= 1'b0;
      rate_q <= rate_t'(MIN_BITS);
    end else begin
      sclk_d       <= sclk_s;
      frame_done_o <= go && last;
      if (go)    cnt_q  <= last ? '0 : cnt_q + 1'b1;
      if (start) rate_q <= rate_to_bits(rate_code_i);
    end
  end

  cfc_tx u_tx (
    .clk_i, .rst_ni, .we_i(tx_we_i), .addr_i(tx_addr_i), .wdata_i(tx_wdata_i),
    .cnt_i(cnt_q), .rate_bits_i(rate_q), .sdo_o
  );

  cfc_rx #(.HDR_WORD(HDR_WORD)) u_rx (
    .clk_i, .rst_ni, .go_i(go), .cnt_i(cnt_q), .sdi_i(sdi_s),
    .word_o(rx_word_o), .idx_o(rx_idx_o), .vld_o(rx_vld_o),
    .hdr_err_o, .ok_o(rx_ok_o)
  );

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> cnt_q == '0); // R5
  AST_RATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && $past(cnt_q) != '0) |-> $stable(rate_q)); // R4
  AST_RATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_q >= rate_t'(MIN_BITS) && rate_q <= rate_t'(MAX_BITS)); // R3
  AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= cnt_t'(PAY_OFS) && (cnt_q - cnt_t'(PAY_OFS)) >= cnt_t'(rate_q))
      |=> !sdo_o); // R3
endmodule

// File: tb/chan_frame_codec_tb_top.sv
module chan_frame_codec_tb_top;
  localparam logic [15:0] HDR = 16'hA5C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_we = 1'b0, sclk = 1'b0, fs = 1'b0, sdi = 1'b0;
  logic [4:0]  tx_addr = '0;
  logic [15:0] tx_wdata = '0;
  logic [7:0]  rate_code = '0;
  logic sdo, rx_vld, hdr_err, rx_ok, done;
  logic [15:0] rx_word;
  logic [4:0]  rx_idx;

  int n_chk = 0, n_err = 0;
  int done_cnt = 0, ok_cnt = 0, err_cnt = 0;
  logic [15:0] txw [17];
  logic [15:0] rxw [17];
  logic [20:0] exp_q [$];

  always #10 clk = ~clk;

  chan_frame_codec #(.HDR_WORD(HDR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_we_i(tx_we), .tx_addr_i(tx_addr),
    .tx_wdata_i(tx_wdata), .rate_code_i(rate_code), .sclk_i(sclk), .fs_i(fs),
    .sdi_i(sdi), .sdo_o(sdo), .rx_word_o(rx_word), .rx_idx_o(rx_idx),
    .rx_vld_o(rx_vld), .hdr_err_o(hdr_err), .rx_ok_o(rx_ok), .frame_done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected received words as the design delivers them
  always @(negedge clk) if (rst_n) begin
    if (rx_vld) begin
      if (exp_q.size() == 0) chk("R7 unexpected word", {11'd0, rx_idx, rx_word}, 32'hFFFF_FFFF);
      else chk("R6 rx word", {11'd0, rx_idx, rx_word}, {11'd0, exp_q.pop_front()});
    end
    if (hdr_err) err_cnt++;
    if (rx_ok)   ok_cnt++;
    if (done)    done_cnt++;
  end

  function automatic int pay_bits(input logic [7:0] code);
    return (code > 8'd144) ? 192 : 48 + int'(code);
  endfunction

  task automatic write_word(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); tx_we = 1'b1; tx_addr = a; tx_wdata = d;
    @(negedge clk); tx_we = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] code, input logic [7:0] mid_code, input bit good);
    int nb, d0, o0, e0;
    logic [15:0] got, expw;
    nb = pay_bits(code);
    for (int i = 0; i < 17; i++) write_word(5'(i), txw[i]);
    rate_code = code;
    rxw[0] = good ? HDR : ~HDR;
    if (good) for (int i = 1; i < 17; i++) exp_q.push_back({5'(i), rxw[i]});
    d0 = done_cnt; o0 = ok_cnt; e0 = err_cnt;
    got = '0;
    for (int k = 0; k < 272; k++) begin
      sclk = 1'b0; fs = (k == 0); sdi = rxw[k/16][15 - k%16];
      repeat (5) @(negedge clk);
      got[15 - k%16] = sdo;
      if (k % 16 == 15) begin
        for (int b = 0; b < 16; b++) begin
          int p;
          p = (k/16)*16 + b;
          expw[15-b] = (p < 80 || p - 80 < nb) ? txw[k/16][15-b] : 1'b0;
        end
        chk((k/16 < 5) ? "R1 tx word" : "R3 tx payload", {16'd0, got}, {16'd0, expw});
      end
      sclk = 1'b1;
      if (k == 100) rate_code = mid_code; // R4: must not affect this frame
      repeat (5) @(negedge clk);
    end
    sclk = 1'b0; fs = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 one done pulse", done_cnt, d0 + 1);
    chk("R6 rx_ok count", ok_cnt, o0 + (good ? 1 : 0));
    chk("R7 hdr_err count", err_cnt, e0 + (good ? 0 : 1));
    chk("R6 all words seen", exp_q.size(), 0);
    chk("R1 idle sdo is word0 msb", {31'd0, sdo}, {31'd0, txw[0][15]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R5 watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 sdo reset", {31'd0, sdo}, 0);
    chk("R9 pulses reset", {28'd0, rx_vld, hdr_err, rx_ok, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 sdo after release", {31'd0, sdo}, 0);

    // full rate, good header
    for (int i = 0; i < 17; i++) begin
      txw[i] = 16'((i + 1) * 16'h2B5D) ^ 16'hC3A5;
      rxw[i] = 16'((i + 7) * 16'h1F3B) ^ 16'h5A0F;
    end
    run_frame(8'd144, 8'd144, 1'b1);

    // minimum rate, bad header: R3 zero fill from bit 128, R7 drop
    for (int i = 0; i < 17; i++) txw[i] = 16'hFFFF;
    run_frame(8'd0, 8'd0, 1'b0);

    // 98 payload bits, ends mid word 11; rate raised mid-frame (R4)
    for (int i = 1; i < 17; i++) rxw[i] = 16'(i * 16'h0F0F) ^ 16'h8001;
    run_frame(8'd50, 8'd144, 1'b1);

    // R8: out-of-range writes ignored; R2: stray clocks ignored
    for (int a = 17; a < 32; a++) write_word(5'(a), 16'h0000);
    for (int i = 0; i < 17; i++) txw[i] = 16'hFFFF ^ 16'(i * 16'h0101);
    for (int i = 0; i < 17; i++) write_word(5'(i), txw[i]);
    for (int a = 17; a < 32; a++) write_word(5'(a), 16'h0000);
    begin
      int d0;
      d0 = done_cnt;
      for (int s = 0; s < 3; s++) begin
        sclk = 1'b1; repeat (5) @(negedge clk);
        sclk = 1'b0; repeat (5) @(negedge clk);
      end
      chk("R2 stray clocks no frame", done_cnt, d0);
      chk("R2 sdo still bit0", {31'd0, sdo}, {31'd0, txw[0][15]});
    end
    // code above 144 clamps to 192 bits
    run_frame(8'd255, 8'd0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule